// File: doc/BRIEF.md
# NAND Strobe Timing Sequencer

This block produces the active-low write and read strobes of an asynchronous NAND bus for single-byte transfers. Every phase of a bus cycle is timed in clock ticks, and the length of each phase comes from its own 8-bit field in one of two 32-bit timing words. Software fills those words with tick counts rounded up from the datasheet times of the device. The control path asks for one transfer at a time. A write request carries a data byte. A read request returns the byte that the device drives onto the bus.

Each operation starts by waiting for the device to report ready, followed by a programmable delay. For a write, the data output enable is raised and the write strobe is pulsed low and then high, followed by an extra wait. For a read, the read strobe is pulsed low and the bus byte is captured once the access time has passed. A high hold and a bus-release interval follow the read pulse. The flag `busy` covers the whole operation. The latch-enable and chip-enable lines are handled elsewhere and pass straight through this block.

Top module: `nand_strobe_timer`

## Requirements
- R1: During and right after reset, `bus_we_n` and `bus_re_n` are 1, `bus_dout_oe` and `busy` are 0, and `rd_data` is 0.
- R2: `timing_wr` holds four tick fields. Bits [31:24] give the ready delay D, bits [23:16] the post-write wait E, bits [15:8] the write cycle C, and bits [7:0] the WE-high count H. `timing_rd` holds four more. Bits [31:24] give the access time A, bits [23:16] the RE-high hold R, bits [15:8] the read pulse P, and bits [7:0] the bus-release time X. A field value of 0 acts as 1.
- R3: When `busy` is 0 at a rising edge, a high `wr_req` starts a write. Otherwise a high `rd_req` starts a read, so a write wins when both are high. Requests seen while `busy` is 1 are dropped. `busy` rises in the cycle after acceptance and falls when the last phase ends.
- R4: Every operation begins with a ready phase that lasts D cycles in which `dev_ready` is 1. Cycles with `dev_ready` at 0 do not count. `dev_ready` has no effect in any other phase.
- R5: A write holds `bus_we_n` low for C−H cycles, or for 1 cycle when C ≤ H. It then holds `bus_we_n` high for H cycles, then waits E cycles.
- R6: `bus_dout_oe` is 1 from the ready phase of a write through its WE-high phase, and 0 at all other times. While it is 1, `bus_dout` shows the `wr_data` byte captured at acceptance.
- R7: A read holds `bus_re_n` low for max(A, P) cycles, then keeps it high for R hold cycles, then for X release cycles. The two strobes are never low together.
- R8: `rd_data` loads `bus_din` at the rising edge that ends the A-th cycle of `bus_re_n` low. It keeps that value until the next capture.
- R9: Both timing words are latched at acceptance. Changing them during an operation does not affect that operation.
- R10: `ctl_out` always equals `ctl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Start a write when idle |
| wr_data | input | 8 | Byte to write, taken at acceptance |
| rd_req | input | 1 | Start a read when idle |
| dev_ready | input | 1 | Device ready indication |
| timing_wr | input | 32 | Ready/write tick fields |
| timing_rd | input | 32 | Read tick fields |
| bus_din | input | 8 | Byte driven by the device |
| ctl_in | input | 3 | Chip/latch enables to pass through |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dout | output | 8 | Byte driven to the device |
| bus_dout_oe | output | 1 | Output enable for `bus_dout` |
| rd_data | output | 8 | Last captured read byte |
| busy | output | 1 | Operation in progress |
| ctl_out | output | 3 | Copy of `ctl_in` |

## Verification
The assertions check the relations between outputs that must hold on every cycle. The two strobes are never low together. A low write strobe implies the output enable, and a low read strobe implies a read in progress. The read byte and the output byte only change where a capture or acceptance is allowed, and an accepted request always raises `busy` on the next cycle. Only the bench's scenarios show the exact phase lengths. These include the zero-field and C ≤ H corner cases, stalls on `dev_ready`, the capture point relative to a changing `bus_din`, dropped requests, and timing words changed mid-operation.

// File: rtl/nst_pkg.sv
`timescale 1ns/1ps
package nst_pkg;
   typedef enum logic [3:0] {
      PH_IDLE, PH_W_RDY, PH_W_LOW, PH_W_HIGH, PH_W_EXT,
      PH_R_RDY, PH_R_LOW, PH_R_HOLD, PH_R_REL
   } phase_e;

   function automatic phase_e phase_succ(input phase_e p);
      case (p)
         PH_W_RDY:  return PH_W_LOW;
         PH_W_LOW:  return PH_W_HIGH;
         PH_W_HIGH: return PH_W_EXT;
         PH_R_RDY:  return PH_R_LOW;
         PH_R_LOW:  return PH_R_HOLD;
         PH_R_HOLD: return PH_R_REL;
         default:   return PH_IDLE;
      endcase
   endfunction

   function automatic logic is_ready_phase(input phase_e p);
      return (p == PH_W_RDY) || (p == PH_R_RDY);
   endfunction
endpackage

// File: rtl/nst_tick_unpack.sv
`timescale 1ns/1ps
module nst_tick_unpack #(
   parameter int TICK_W = 8,
   parameter int FIELDS = 4,
   localparam int WORD_W = TICK_W * FIELDS
) (
   input  logic [WORD_W-1:0]             word,
   output logic [FIELDS-1:0][TICK_W-1:0] ticks
);
   localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

   for (genvar i = 0; i < FIELDS; i++) begin : g_field
      logic [TICK_W-1:0] raw;
      assign raw      = word[WORD_W-1-i*TICK_W -: TICK_W];
      assign ticks[i] = (raw == '0) ? ONE : raw;
   end
endmodule

// File: rtl/nst_phase_len.sv
`timescale 1ns/1ps
module nst_phase_len
   import nst_pkg::*;
#(
   parameter int TICK_W = 8
) (
   input  phase_e                   phase,
   input  logic [3:0][TICK_W-1:0]   wt,
   input  logic [3:0][TICK_W-1:0]   rt,
   output logic [TICK_W-1:0]        len
);
   localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

   logic [TICK_W-1:0] we_low_len;
   logic [TICK_W-1:0] re_low_len;

   assign we_low_len = (wt[2] > wt[3]) ? (wt[2] - wt[3]) : ONE;
   assign re_low_len = (rt[0] > rt[2]) ? rt[0] : rt[2];

   always_comb begin
      case (phase)
         PH_W_RDY,
         PH_R_RDY:  len = wt[0];
         PH_W_LOW:  len = we_low_len;
         PH_W_HIGH: len = wt[3];
         PH_W_EXT:  len = wt[1];
         PH_R_LOW:  len = re_low_len;
         PH_R_HOLD: len = rt[1];
         PH_R_REL:  len = rt[3];
         default:   len = ONE;
      endcase
   end
endmodule

// File: rtl/nst_sequencer.sv
`timescale 1ns/1ps
module nst_sequencer
   import nst_pkg::*;
#(
   parameter int TICK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic              dev_ready,
   input  logic [TICK_W-1:0] len,
   output phase_e            phase,
   output logic [TICK_W-1:0] tick,
   output logic              accept,
   output logic              we_n,
   output logic              re_n,
   output logic              oe,
   output logic              busy
);
   localparam logic [TICK_W-1:0] ONE = TICK_W'(1);

   phase_e            ph_d;
   logic [TICK_W-1:0] tick_d;
   logic              gate;

   always_comb begin
      ph_d   = phase;
      tick_d = tick;
      accept = 1'b0;
      gate   = is_ready_phase(phase) ? dev_ready : 1'b1;
      if (phase == PH_IDLE) begin
         if (wr_req) begin
            ph_d   = PH_W_RDY;
            tick_d = ONE;
            accept = 1'b1;
         end else if (rd_req) begin
            ph_d   = PH_R_RDY;
            tick_d = ONE;
            accept = 1'b1;
         end
      end else if (gate) begin
         if (tick == len) begin
            ph_d   = phase_succ(phase);
            tick_d = ONE;
         end else begin
            tick_d = tick + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tick  <= ONE;
         we_n  <= 1'b1;
         re_n  <= 1'b1;
         oe    <= 1'b0;
         busy  <= 1'b0;
      end else begin
         phase <= ph_d;
         tick  <= tick_d;
         we_n  <= (ph_d != PH_W_LOW);
         re_n  <= (ph_d != PH_R_LOW);
         oe    <= (ph_d == PH_W_RDY) || (ph_d == PH_W_LOW) || (ph_d == PH_W_HIGH);
         busy  <= (ph_d != PH_IDLE);
      end
   end
endmodule

// File: rtl/nand_strobe_timer.sv
`timescale 1ns/1ps
module nand_strobe_timer
   import nst_pkg::*;
#(
   parameter int TICK_W = 8,
   parameter int DATA_W = 8,
   parameter int CTL_W  = 3,
   localparam int FIELDS = 4,
   localparam int WORD_W = TICK_W * FIELDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic              dev_ready,
   input  logic [WORD_W-1:0] timing_wr,
   input  logic [WORD_W-1:0] timing_rd,
   input  logic [DATA_W-1:0] bus_din,
   input  logic [CTL_W-1:0]  ctl_in,
   output logic              bus_we_n,
   output logic              bus_re_n,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_dout_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic [CTL_W-1:0]  ctl_out
);
   if (TICK_W < 2) begin : g_bad_tick
      $error("nand_strobe_timer: TICK_W must be at least 2");
   end
   if (DATA_W < 1 || CTL_W < 1) begin : g_bad_width
      $error("nand_strobe_timer: DATA_W and CTL_W must be positive");
   end

   logic [WORD_W-1:0]             wr_word_q;
   logic [WORD_W-1:0]             rd_word_q;
   logic [DATA_W-1:0]             data_q;
   logic [FIELDS-1:0][TICK_W-1:0] wt;
   logic [FIELDS-1:0][TICK_W-1:0] rt;
   logic [TICK_W-1:0]             len;
   logic [TICK_W-1:0]             tick;
   phase_e                        phase;
   logic                          accept;

   nst_tick_unpack #(.TICK_W(TICK_W), .FIELDS(FIELDS)) u_unpack_wr (
      .word(wr_word_q), .ticks(wt));
   nst_tick_unpack #(.TICK_W(TICK_W), .FIELDS(FIELDS)) u_unpack_rd (
      .word(rd_word_q), .ticks(rt));

   nst_phase_len #(.TICK_W(TICK_W)) u_len (
      .phase(phase), .wt(wt), .rt(rt), .len(len));

   nst_sequencer #(.TICK_W(TICK_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
      .dev_ready(dev_ready), .len(len), .phase(phase), .tick(tick),
      .accept(accept), .we_n(bus_we_n), .re_n(bus_re_n),
      .oe(bus_dout_oe), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_word_q <= '0;
         rd_word_q <= '0;
         data_q    <= '0;
      end else if (accept) begin
         wr_word_q <= timing_wr;
         rd_word_q <= timing_rd;
         if (wr_req) data_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (phase == PH_R_LOW && tick == rt[0])
         rd_data <= bus_din;
   end

   assign bus_dout = data_q;
   assign ctl_out  = ctl_in;
endmodule

// File: rtl/nst_checker.sv
`timescale 1ns/1ps
module nst_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              rd_req,
   input logic              bus_we_n,
   input logic              bus_re_n,
   input logic              bus_dout_oe,
   input logic [DATA_W-1:0] bus_dout,
   input logic [DATA_W-1:0] rd_data,
   input logic              busy
);
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_we_n && !bus_re_n));

   assert_oe_in_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_dout_oe |-> busy);

   assert_we_with_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> bus_dout_oe);

   assert_re_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re_n |-> (busy && !bus_dout_oe));

   assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_re_n) |-> $stable(rd_data));

   assert_dout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_dout_oe && $past(bus_dout_oe)) |-> $stable(bus_dout));

   assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (wr_req || rd_req)) |=> busy);

   assert_wr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && wr_req) |=> bus_dout_oe);
endmodule

bind nand_strobe_timer nst_checker #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
   .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_dout_oe(bus_dout_oe),
   .bus_dout(bus_dout), .rd_data(rd_data), .busy(busy));

// File: tb/nand_strobe_timer_tb.sv
`timescale 1ns/1ps
module nand_strobe_timer_tb_top;
   localparam int K_WRDY = 1, K_WLOW = 2, K_WHIGH = 3, K_WEXT = 4;
   localparam int K_RRDY = 5, K_RLOW = 6, K_RHOLD = 7, K_RREL = 8;
   localparam int LIMIT = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_req = 1'b0, rd_req = 1'b0, dev_ready = 1'b1;
   logic [7:0]  wr_data = 8'h00, bus_din = 8'h00;
   logic [31:0] timing_wr = 32'h0, timing_rd = 32'h0;
   logic [2:0]  ctl_in = 3'b000;
   logic        bus_we_n, bus_re_n, bus_dout_oe, busy;
   logic [7:0]  bus_dout, rd_data;
   logic [2:0]  ctl_out;

   always #2.5 clk = ~clk;

   nand_strobe_timer dut_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
      .rd_req(rd_req), .dev_ready(dev_ready), .timing_wr(timing_wr),
      .timing_rd(timing_rd), .bus_din(bus_din), .ctl_in(ctl_in),
      .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_dout(bus_dout),
      .bus_dout_oe(bus_dout_oe), .rd_data(rd_data), .busy(busy),
      .ctl_out(ctl_out));

   int n_checks = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0, cmp_en = 1'b0, toggle_rdy = 1'b0;
   int we_low = 0, re_low = 0, busy_cnt = 0;

   // behavioural reference: a queue of remaining phases
   int q_kind[$];
   int q_left[$];
   logic [7:0] m_data = 8'h00, m_rd = 8'h00;
   int m_acc = 1, r_elapsed = 0;

   function automatic int cl(input logic [7:0] v);
      return (v == 8'd0) ? 1 : int'(v);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q_kind.delete(); q_left.delete();
         m_rd = 8'h00; m_data = 8'h00; r_elapsed = 0;
      end else if (q_kind.size() != 0) begin
         int k;
         k = q_kind[0];
         if (k == K_RLOW) begin
            r_elapsed++;
            if (r_elapsed == m_acc) m_rd = bus_din;
         end
         if (!((k == K_WRDY || k == K_RRDY) && !dev_ready)) begin
            q_left[0] = q_left[0] - 1;
            if (q_left[0] == 0) begin
               void'(q_kind.pop_front());
               void'(q_left.pop_front());
               r_elapsed = 0;
            end
         end
      end else if (wr_req) begin
         int c, h;
         c = cl(timing_wr[15:8]);
         h = cl(timing_wr[7:0]);
         m_data = wr_data;
         q_kind = '{K_WRDY, K_WLOW, K_WHIGH, K_WEXT};
         q_left = '{cl(timing_wr[31:24]), (c > h) ? c - h : 1, h, cl(timing_wr[23:16])};
      end else if (rd_req) begin
         int a, p;
         a = cl(timing_rd[31:24]);
         p = cl(timing_rd[15:8]);
         m_acc = a;
         r_elapsed = 0;
         q_kind = '{K_RRDY, K_RLOW, K_RHOLD, K_RREL};
         q_left = '{cl(timing_wr[31:24]), (a > p) ? a : p, cl(timing_rd[23:16]), cl(timing_rd[7:0])};
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         int k;
         k = (q_kind.size() != 0) ? q_kind[0] : 0;
         chk(bus_we_n == (k != K_WLOW), "R5 bus_we_n", int'(bus_we_n), int'(k != K_WLOW));
         chk(bus_re_n == (k != K_RLOW), "R7 bus_re_n", int'(bus_re_n), int'(k != K_RLOW));
         chk(bus_dout_oe == (k >= K_WRDY && k <= K_WHIGH), "R6 bus_dout_oe",
             int'(bus_dout_oe), int'(k >= K_WRDY && k <= K_WHIGH));
         chk(busy == (k != 0), "R3 busy", int'(busy), int'(k != 0));
         if (k >= K_WRDY && k <= K_WHIGH)
            chk(bus_dout == m_data, "R6 bus_dout", int'(bus_dout), int'(m_data));
         chk(rd_data == m_rd, "R8 rd_data", int'(rd_data), int'(m_rd));
         chk(ctl_out == ctl_in, "R10 ctl_out", int'(ctl_out), int'(ctl_in));
      end
   end

   always @(negedge clk) begin
      bus_din <= bus_din + 8'h1D;
      if (toggle_rdy) dev_ready <= ~dev_ready;
      #1;
      if (!bus_we_n) we_low++;
      if (!bus_re_n) re_low++;
      if (busy) busy_cnt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT && !done) begin
         done = 1'b1;
         chk(1'b0, "watchdog expired", cyc, LIMIT);
         finish_run();
      end
   end

   task automatic run_op(input bit w, input bit r, input logic [7:0] d);
      @(negedge clk);
      wr_req = w; rd_req = r; wr_data = d;
      we_low = 0; re_low = 0; busy_cnt = 0;
      @(negedge clk);
      wr_req = 1'b0; rd_req = 1'b0;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(bus_we_n && bus_re_n, "R1 strobes idle in reset", int'({bus_we_n, bus_re_n}), 3);
      chk(!bus_dout_oe && !busy, "R1 oe/busy low in reset", int'({bus_dout_oe, busy}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data == 8'h00, "R1 rd_data after reset", int'(rd_data), 0);
      chk(!busy && bus_we_n, "R1 idle after reset", int'({busy, bus_we_n}), 1);
      cmp_en = 1'b1;

      // plain write: D=2 E=3 C=6 H=2 -> WE low 4
      timing_wr = 32'h02_03_06_02;
      timing_rd = 32'h03_02_05_02;
      run_op(1'b1, 1'b0, 8'hA5);
      chk(we_low == 4, "R5 WE low width C-H", we_low, 4);
      chk(busy_cnt == 11, "R5 write busy length", busy_cnt, 11);

      // read with P > A: RE low 5, capture after 3rd low cycle
      run_op(1'b0, 1'b1, 8'h00);
      chk(re_low == 5, "R7 RE low width P", re_low, 5);
      chk(rd_data == m_rd, "R8 captured byte", int'(rd_data), int'(m_rd));

      // read with A > P: RE low stretched to A=6
      timing_rd = 32'h06_01_02_01;
      run_op(1'b0, 1'b1, 8'h00);
      chk(re_low == 6, "R7 RE low width A", re_low, 6);

      // all fields zero act as 1
      timing_wr = 32'h0; timing_rd = 32'h0;
      run_op(1'b1, 1'b0, 8'h3C);
      chk(busy_cnt == 4, "R2 zero fields write length", busy_cnt, 4);
      run_op(1'b0, 1'b1, 8'h00);
      chk(re_low == 1 && busy_cnt == 4, "R2 zero fields read", re_low * 16 + busy_cnt, 20);

      // C <= H -> WE low 1
      timing_wr = 32'h01_01_02_05;
      run_op(1'b1, 1'b0, 8'h5A);
      chk(we_low == 1, "R5 WE low floor", we_low, 1);

      // ready stall
      timing_wr = 32'h02_01_04_01;
      dev_ready = 1'b0;
      @(negedge clk); wr_req = 1'b1; wr_data = 8'h77;
      @(negedge clk); wr_req = 1'b0;
      repeat (5) @(negedge clk);
      chk(busy && bus_we_n, "R4 stalled while not ready", int'({busy, bus_we_n}), 3);
      dev_ready = 1'b1;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);

      // dev_ready toggling throughout a read
      timing_rd = 32'h02_02_04_02;
      toggle_rdy = 1'b1;
      run_op(1'b0, 1'b1, 8'h00);
      toggle_rdy = 1'b0;
      @(negedge clk); dev_ready = 1'b1;
      chk(re_low == 4, "R4 ready ignored after ready phase", re_low, 4);

      // timing words changed mid-operation
      timing_wr = 32'h01_01_08_02;
      @(negedge clk); wr_req = 1'b1; wr_data = 8'h99; we_low = 0;
      @(negedge clk); wr_req = 1'b0; timing_wr = 32'h01_01_02_01;
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(we_low == 6, "R9 latched timing", we_low, 6);

      // request while busy is dropped
      timing_wr = 32'h02_02_05_01;
      @(negedge clk); wr_req = 1'b1; wr_data = 8'h11;
      @(negedge clk); wr_req = 1'b0;
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(!busy && bus_re_n, "R3 busy-time request dropped", int'({busy, bus_re_n}), 1);

      // simultaneous requests: write wins
      @(negedge clk); wr_req = 1'b1; rd_req = 1'b1; wr_data = 8'hC3;
      @(negedge clk); wr_req = 1'b0; rd_req = 1'b0;
      chk(bus_dout_oe == 1'b1, "R3 write priority", int'(bus_dout_oe), 1);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);

      // pass-through
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); ctl_in = 3'(i);
         #1 chk(ctl_out == 3'(i), "R10 pass-through", int'(ctl_out), i);
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule